// File: doc/BRIEF.md
# Receive Frame Alignment Padder

This block sits in the receive byte stream between a MAC and the receive buffer writer. Each frame arrives as a sequence of bytes under a valid/ready handshake, with a start marker on the first byte and an end marker on the last. When the alignment enable is set, the block puts two filler bytes in front of the destination address of each frame. The 14-byte Ethernet header then ends on a 4-byte boundary, so the payload that follows it starts word-aligned in the buffer.

The filler bytes carry no meaning. The block stalls the upstream side for as long as it emits them, so no received byte is dropped or repeated. For every frame it reports a message length that counts only the real bytes. The enable bit can be read and written at any time, and it is examined only when a frame starts. The alignment comes out correct only if the buffer writer starts every receive buffer on a 4-byte boundary and sizes each buffer as a multiple of 4 bytes.

Top module: `rx_align_padder`

## Requirements
- R1: A write (`align_wr` high) loads `align_wdata` into the enable, and `align_q` shows the new value from the next cycle on. Writes are accepted at any time, including in the middle of a frame.
- R2: `rst_n` low or `soft_rst` high clears the enable. `soft_rst` wins over a write in the same cycle. After reset, `out_valid` and `msg_len_vld` are 0.
- R3: When the enable is 1 at the start of a frame, exactly two filler bytes of value `FILL_BYTE` (default 8'h00) come out ahead of the first real byte. `out_sof` is set on the first filler byte only.
- R4: While a filler byte is being offered, `in_ready` is 0. Every input byte appears at the output exactly once and in input order.
- R5: When the enable is 0 at the start of a frame, the frame passes through unchanged, with `out_sof` on its first real byte.
- R6: `out_eof` is set only on the last real byte of a frame and never on a filler byte.
- R7: One cycle after the last byte of a frame is accepted at the output, `msg_len_vld` pulses for one cycle, and `msg_len` holds the number of real bytes in the frame, leaving out the filler.
- R8: The enable is examined only when the start byte of a frame is offered. A change in the middle of a frame does not alter that frame, and the next frame follows the new value.
- R9: While `out_ready` is 0, a filler byte stays offered, with its data and start marker unchanged.
- R10: A one-byte frame (start and end markers on the same byte) with the enable set comes out as three bytes, with a reported length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| soft_rst | input | 1 | Software reset, clears the enable |
| align_wr | input | 1 | Enable write strobe |
| align_wdata | input | 1 | Value written to the enable |
| align_q | output | 1 | Current enable value |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Block accepts the upstream byte |
| in_data | input | DATA_W | Upstream byte |
| in_sof | input | 1 | Upstream start-of-frame marker |
| in_eof | input | 1 | Upstream end-of-frame marker |
| out_valid | output | 1 | Downstream byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | DATA_W | Downstream byte (filler or real) |
| out_sof | output | 1 | Downstream start-of-frame marker |
| out_eof | output | 1 | Downstream end-of-frame marker |
| msg_len | output | CNT_W | Real byte count of the last finished frame |
| msg_len_vld | output | 1 | One-cycle strobe when `msg_len` is updated |

## Verification
On every cycle, the assertions check these rules:
- The upstream side is stalled while filler is offered.
- A started filler run continues to its second byte.
- A filler byte waiting on backpressure holds still.
- No filler appears inside a frame body.
- The length strobe follows each frame end.
- The enable register obeys writes and the software reset.

Only the bench's scenarios can show the rest:
- The whole byte order of each frame.
- The filler count and value.
- The placement of the markers.
- Correct lengths across random frame sizes, random backpressure and a mid-frame change of the enable.

// File: rtl/rxpad_pkg.sv
package rxpad_pkg;

  typedef enum logic [1:0] {
    PH_OPEN = 2'd0,
    PH_FILL = 2'd1,
    PH_BODY = 2'd2
  } pad_phase_e;

  // True when filler index idx is the final one of a run of n
  function automatic logic last_fill(input int idx, input int n);
    return idx == n - 1;
  endfunction

endpackage

// File: rtl/rxpad_cfg.sv
module rxpad_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic wr_en,
  input  logic wr_val,
  output logic align_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        align_q <= 1'b0;
    else if (soft_rst) align_q <= 1'b0;
    else if (wr_en)    align_q <= wr_val;
  end

  // R2
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !align_q);

  // R1
  wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst) |=> (align_q == $past(wr_val)));

endmodule

// File: rtl/rxpad_seq.sv
module rxpad_seq
  import rxpad_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAD_BYTES = 2,
  parameter logic [DATA_W-1:0] FILL_BYTE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              align_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              fill_beat,
  output logic              real_fire,
  output logic              eof_fire
);

  localparam int IDX_W = (PAD_BYTES > 1) ? $clog2(PAD_BYTES) : 1;
  localparam bit HAS_FILL = (PAD_BYTES > 0);

  pad_phase_e       phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             start_fill;
  logic             out_fire;

  always_comb begin
    start_fill = HAS_FILL && (phase_q == PH_OPEN) && in_valid && in_sof && align_en;
    fill_beat  = start_fill || (phase_q == PH_FILL);
    out_valid  = fill_beat ? 1'b1 : in_valid;
    out_data   = fill_beat ? FILL_BYTE : in_data;
    out_sof    = (phase_q == PH_OPEN) && in_sof && in_valid;
    out_eof    = fill_beat ? 1'b0 : in_eof;
    in_ready   = fill_beat ? 1'b0 : out_ready;
    out_fire   = out_valid && out_ready;
    real_fire  = out_fire && !fill_beat;
    eof_fire   = real_fire && in_eof;
  end

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    unique case (phase_q)
      PH_OPEN: begin
        if (start_fill && out_ready) begin
          if (last_fill(0, PAD_BYTES)) begin
            phase_d = PH_BODY;
          end else begin
            phase_d = PH_FILL;
            idx_d   = IDX_W'(1);
          end
        end else if (real_fire && in_sof && !in_eof) begin
          phase_d = PH_BODY;
        end
      end
      PH_FILL: begin
        if (out_ready) begin
          if (last_fill(int'(idx_q), PAD_BYTES)) begin
            phase_d = PH_BODY;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      PH_BODY: begin
        if (eof_fire) phase_d = PH_OPEN;
      end
      default: phase_d = PH_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPEN;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  // R4
  fill_stalls_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_beat |-> !in_ready);

  // R3
  fill_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (PAD_BYTES > 1 && start_fill && out_ready) |=> (fill_beat && !out_sof));

  // R9
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FILL && !out_ready) |=>
      (fill_beat && out_data == $past(out_data) && out_sof == $past(out_sof)));

  // R8
  body_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BODY && !eof_fire) |=> !fill_beat);

endmodule

// File: rtl/rxpad_len.sv
module rxpad_len #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             real_fire,
  input  logic             eof_fire,
  output logic [CNT_W-1:0] msg_len,
  output logic             msg_len_vld
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      msg_len     <= '0;
      msg_len_vld <= 1'b0;
    end else begin
      msg_len_vld <= 1'b0;
      if (real_fire) begin
        if (eof_fire) begin
          cnt_q       <= '0;
          msg_len     <= bump(cnt_q);
          msg_len_vld <= 1'b1;
        end else begin
          cnt_q <= bump(cnt_q);
        end
      end
    end
  end

  // R7
  len_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_fire |=> msg_len_vld);

  // R7
  len_only_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_len_vld |-> $past(eof_fire));

endmodule

// File: rtl/rx_align_padder.sv
module rx_align_padder #(
  parameter int DATA_W = 8,
  parameter int PAD_BYTES = 2,
  parameter int CNT_W = 16,
  parameter logic [DATA_W-1:0] FILL_BYTE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              align_wr,
  input  logic              align_wdata,
  output logic              align_q,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic [CNT_W-1:0]  msg_len,
  output logic              msg_len_vld
);

  logic fill_beat;
  logic real_fire;
  logic eof_fire;

  rxpad_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .wr_en    (align_wr),
    .wr_val   (align_wdata),
    .align_q  (align_q)
  );

  rxpad_seq #(
    .DATA_W    (DATA_W),
    .PAD_BYTES (PAD_BYTES),
    .FILL_BYTE (FILL_BYTE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .align_en  (align_q),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .fill_beat (fill_beat),
    .real_fire (real_fire),
    .eof_fire  (eof_fire)
  );

  rxpad_len #(
    .CNT_W (CNT_W)
  ) u_len (
    .clk         (clk),
    .rst_n       (rst_n),
    .real_fire   (real_fire),
    .eof_fire    (eof_fire),
    .msg_len     (msg_len),
    .msg_len_vld (msg_len_vld)
  );

  // R6
  no_eof_on_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_beat && out_ready) |=> !msg_len_vld);

endmodule

// File: tb/rx_align_padder_tb_top.sv
`timescale 1ns/100ps
module rx_align_padder_tb_top;

  localparam int DATA_W = 8;
  localparam int PAD = 2;
  localparam int CNT_W = 16;
  localparam logic [7:0] FILL = 8'h00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic align_wr = 1'b0;
  logic align_wdata = 1'b0;
  logic align_q;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic in_sof = 1'b0;
  logic in_eof = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_data;
  logic out_sof;
  logic out_eof;
  logic [CNT_W-1:0] msg_len;
  logic msg_len_vld;

  always #2 clk = ~clk;

  rx_align_padder #(.DATA_W(DATA_W), .PAD_BYTES(PAD), .CNT_W(CNT_W), .FILL_BYTE(FILL)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .align_wr(align_wr), .align_wdata(align_wdata), .align_q(align_q),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof),
    .msg_len(msg_len), .msg_len_vld(msg_len_vld)
  );

  int checks = 0;
  int errors = 0;
  int rdy_pct = 100;
  int gap_pct = 0;
  bit en_shadow = 1'b0;
  bit mon_on = 1'b0;
  bit len_pend = 1'b0;
  logic [10:0] exp_q[$];   // {is_fill, sof, eof, data}
  int len_q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected output beat for filler or real byte
  function automatic logic [10:0] mk_beat(input bit fill, input bit sof, input bit eof, input logic [7:0] d);
    return {fill, sof, eof, d};
  endfunction

  // message length excludes filler
  function automatic int exp_len(input int nbytes);
    return nbytes;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      out_ready = (($urandom % 100) < rdy_pct);
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (mon_on) begin
        if (len_pend) begin
          int e;
          e = len_q.pop_front();
          chk(msg_len_vld == 1'b1, "R7", "length strobe", int'(msg_len_vld), 1);
          chk(int'(msg_len) == e, "R7", "message length", int'(msg_len), e);
          len_pend = 1'b0;
        end else begin
          chk(msg_len_vld == 1'b0, "R7", "spurious length strobe", int'(msg_len_vld), 0);
        end
        if (exp_q.size() > 0 && exp_q[0][10] && in_valid)
          chk(in_ready == 1'b0, "R4", "in_ready during filler", int'(in_ready), 0);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected output byte", int'(out_data), -1);
          end else begin
            logic [10:0] b;
            string tg;
            b = exp_q.pop_front();
            tg = b[10] ? "R3" : "R4";
            chk(out_data == b[7:0], tg, "byte value", int'(out_data), int'(b[7:0]));
            chk(out_sof == b[9], b[10] ? "R3" : "R5", "start marker", int'(out_sof), int'(b[9]));
            chk(out_eof == b[8], "R6", "end marker", int'(out_eof), int'(b[8]));
            if (out_eof) len_pend = 1'b1;
          end
        end
      end
    end
  end

  task automatic send_frame(input int len, input int flip_idx);
    logic [7:0] bytes[];
    bit en0;
    bytes = new[len];
    en0 = en_shadow;
    for (int i = 0; i < len; i++) bytes[i] = 8'($urandom);
    if (en0) begin
      exp_q.push_back(mk_beat(1'b1, 1'b1, 1'b0, FILL));
      for (int k = 1; k < PAD; k++) exp_q.push_back(mk_beat(1'b1, 1'b0, 1'b0, FILL));
    end
    for (int i = 0; i < len; i++)
      exp_q.push_back(mk_beat(1'b0, (i == 0) && !en0, i == len - 1, bytes[i]));
    len_q.push_back(exp_len(len));
    for (int i = 0; i < len; i++) begin
      bit acc;
      while (($urandom % 100) < gap_pct) begin
        @(negedge clk);
        in_valid = 1'b0;
        align_wr = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data = bytes[i];
      in_sof = (i == 0);
      in_eof = (i == len - 1);
      align_wr = (i == flip_idx);
      if (i == flip_idx) begin
        align_wdata = ~en_shadow;
        en_shadow = ~en_shadow;
      end
      #1;
      acc = in_ready;
      while (!acc) begin
        @(negedge clk);
        align_wr = 1'b0;
        #1;
        acc = in_ready;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof = 1'b0;
    in_eof = 1'b0;
    align_wr = 1'b0;
  endtask

  task automatic write_en(input bit v);
    @(negedge clk);
    align_wr = 1'b1;
    align_wdata = v;
    @(negedge clk);
    align_wr = 1'b0;
    en_shadow = v;
  endtask

  task automatic drain();
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !len_pend) break;
    end
    #3;
    chk(exp_q.size() == 0, "R4", "bytes left undelivered", exp_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(align_q == 1'b0, "R2", "enable after reset", int'(align_q), 0);
    chk(out_valid == 1'b0, "R2", "out_valid after reset", int'(out_valid), 0);
    chk(msg_len_vld == 1'b0, "R2", "length strobe after reset", int'(msg_len_vld), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1 write and read back
    write_en(1'b1);
    #1 chk(align_q == 1'b1, "R1", "enable readback", int'(align_q), 1);
    // R2 software reset clears, wins over write
    @(negedge clk);
    soft_rst = 1'b1;
    align_wr = 1'b1;
    align_wdata = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    align_wr = 1'b0;
    en_shadow = 1'b0;
    #1 chk(align_q == 1'b0, "R2", "enable after soft reset", int'(align_q), 0);

    // R5 disabled frames
    rdy_pct = 70; gap_pct = 20;
    for (int f = 0; f < 6; f++) send_frame(1 + int'($urandom % 40), -1);
    drain();

    // R3 R7 enabled frames
    write_en(1'b1);
    for (int f = 0; f < 8; f++) send_frame(14 + int'($urandom % 50), -1);
    drain();

    // R10 one-byte frames with filler
    for (int f = 0; f < 3; f++) send_frame(1, -1);
    drain();

    // R8 enable flips mid-frame: current frame keeps its start value
    send_frame(20, 5);
    send_frame(10, -1);
    send_frame(12, 3);
    send_frame(9, -1);
    drain();
    #0 chk(align_q == en_shadow, "R8", "enable after mid-frame writes", int'(align_q), int'(en_shadow));

    // R9 heavy backpressure during filler
    write_en(1'b1);
    rdy_pct = 15; gap_pct = 0;
    for (int f = 0; f < 6; f++) send_frame(2 + int'($urandom % 20), -1);
    drain();

    // mixed random
    rdy_pct = 60; gap_pct = 30;
    for (int f = 0; f < 30; f++) begin
      if (($urandom % 4) == 0) write_en(1'($urandom));
      send_frame(1 + int'($urandom % 64), (($urandom % 5) == 0) ? 1 + int'($urandom % 3) : -1);
    end
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog: actual=%0d expected=%0d cycles", 150000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule